// File: doc/BRIEF.md
# Programmable Asynchronous Logic Output Cell

This block is one configurable output cell of a sum-of-products logic device. A small programmable AND array takes the device inputs and the cell's own feedback. It forms eight product terms. Four of them are ORed into the data value. The other four drive the storage element's clock, its set, its reset and the output enable. Each product term's literals are chosen by a static fuse mask that arrives on input ports.

The cell runs in one of two modes. In registered mode the data value is captured on a rising edge of the clock product term, and the set and reset product terms act at any time. In combinatorial mode the storage element is bypassed. That mode is chosen whenever the set and reset terms are both high. A polarity bit selects whether the pad carries the value or its complement. The pad is driven only when the enable term is high and the shared enable pin is low. A preload pin forces the stored state from the level on the pad. The block's reset stands for power-up and clears the storage element.

The asynchronous control terms are sampled on a fast system clock. An edge of the clock term is therefore recognised between two samples, and set and reset act as levels at each sample. The array reads the feedback as the pad level seen at the previous sample, and this break keeps combinatorial feedback free of zero-delay loops.

Top module: `asyn_macrocell`

## Requirements
- R1: A product term is the AND of the literals its 2×N mask connects. Mask bit 2i connects array input i true and bit 2i+1 connects it complemented. Array inputs 0..N-2 are the device inputs and input N-1 is the feedback. A mask of all ones gives a low term and a mask of all zeros gives a high term.
- R2: The data value is the OR of the four data terms. Data term k uses mask bits [k*2N +: 2N]. In registered mode the stored state takes the data value at each sample where the clock term is high after being low, and at no other time.
- R3: pad_oe is high only when the enable term is high and oe_pin_n is low. With oe_pin_n high, or with the enable term low, the pad is not driven.
- R4: With the set and reset terms both high, pad_out follows the data value combinationally and the stored state holds its value.
- R5: With only the set term high the stored state becomes 1, and with only the reset term high it becomes 0, whatever the clock term does in that sample.
- R6: With cfg_active_high = 1 pad_out equals the selected value (data value or stored state). With cfg_active_high = 0 pad_out is its complement.
- R7: While preload_n is low, the stored state is loaded so that pad_out shows pad_in in registered mode. Preload outranks set, reset and clock.
- R8: Reset clears the stored state to 0. An active-low registered cell therefore shows pad_out = 1 after reset.
- R9: The feedback input is the pad level at the previous sample. That level is pad_out when pad_oe is high and pad_in otherwise. This lets a registered cell step through states and lets a disabled cell act as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-up reset |
| dev_in | input | N_IN | Device input pins feeding the array |
| oe_pin_n | input | 1 | Shared external output enable, active low |
| preload_n | input | 1 | Preload control, active low |
| pad_in | input | 1 | Level on the pad when driven from outside |
| fuse_data | input | 4*2*(N_IN+1) | Masks of the four data terms |
| fuse_clk | input | 2*(N_IN+1) | Mask of the clock term |
| fuse_set | input | 2*(N_IN+1) | Mask of the set term |
| fuse_rst | input | 2*(N_IN+1) | Mask of the reset term |
| fuse_oe | input | 2*(N_IN+1) | Mask of the enable term |
| cfg_active_high | input | 1 | Output polarity, 1 = active high |
| pad_out | output | 1 | Value the cell drives on the pad |
| pad_oe | output | 1 | Pad driver enable |

## Verification
Two actions can fall in the same sample: a rising edge of the clock term, and a set or reset level. The bench raises the clock input together with the set input while the data value is 0. It then raises the clock input together with the reset input while the data value is 1. It judges the result by the pad one sample later, which must show the forced level and not the data value. The bench also releases set and reset together out of combinatorial mode. It checks that the held state, and not the last combinatorial value, reappears on the pad.

// File: rtl/mc_pkg.sv
package mc_pkg;
    // State held by the cell between samples
    typedef struct packed {
        logic state;     // stored D value, before polarity
        logic clk_prev;  // clock term at previous sample
        logic fb;        // pad level at previous sample
    } mc_regs_t;
endpackage

// File: rtl/pt_term.sv
module pt_term #(
    parameter int N = 11
) (
    input  logic [N-1:0]   lits,
    input  logic [2*N-1:0] mask,
    output logic           term
);
    localparam int W = 2 * N;

    logic [W-1:0] both_rails;

    generate
        for (genvar i = 0; i < N; i++) begin : g_rail
            assign both_rails[2*i]   = lits[i];
            assign both_rails[2*i+1] = ~lits[i];
        end
    endgenerate

    // An unconnected literal contributes a 1 to the AND
    assign term = &(~mask | both_rails);
endmodule

// File: rtl/pt_array.sv
module pt_array #(
    parameter int N     = 11,
    parameter int N_DAT = 4
) (
    input  logic [N-1:0]         lits,
    input  logic [N_DAT*2*N-1:0] fuse_data,
    input  logic [2*N-1:0]       fuse_clk,
    input  logic [2*N-1:0]       fuse_set,
    input  logic [2*N-1:0]       fuse_rst,
    input  logic [2*N-1:0]       fuse_oe,
    output logic                 sum,
    output logic                 clk_t,
    output logic                 set_t,
    output logic                 rst_t,
    output logic                 oe_t
);
    localparam int MW = 2 * N;

    logic [N_DAT-1:0] dat_t;

    generate
        for (genvar k = 0; k < N_DAT; k++) begin : g_dat
            pt_term #(.N(N)) u_term (
                .lits (lits),
                .mask (fuse_data[k*MW +: MW]),
                .term (dat_t[k])
            );
        end
    endgenerate

    pt_term #(.N(N)) u_clk (.lits(lits), .mask(fuse_clk), .term(clk_t));
    pt_term #(.N(N)) u_set (.lits(lits), .mask(fuse_set), .term(set_t));
    pt_term #(.N(N)) u_rst (.lits(lits), .mask(fuse_rst), .term(rst_t));
    pt_term #(.N(N)) u_oe  (.lits(lits), .mask(fuse_oe),  .term(oe_t));

    assign sum = |dat_t;
endmodule

// File: rtl/mc_state.sv
module mc_state
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic preload_n,
    input  logic pad_in,
    input  logic active_high,
    input  logic sum,
    input  logic clk_t,
    input  logic set_t,
    input  logic rst_t,
    input  logic pad_level,
    output logic state_q,
    output logic fb_q
);
    mc_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.clk_prev = clk_t;
        r_d.fb       = pad_level;
        if (!preload_n) begin
            // store so that the pad shows the impressed level
            r_d.state = active_high ? pad_in : ~pad_in;
        end else if (set_t && !rst_t) begin
            r_d.state = 1'b1;
        end else if (rst_t && !set_t) begin
            r_d.state = 1'b0;
        end else if (set_t && rst_t) begin
            r_d.state = r_q.state;
        end else if (clk_t && !r_q.clk_prev) begin
            r_d.state = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= 1'b0;
            r_q.clk_prev <= 1'b1;
            r_q.fb       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.state;
    assign fb_q    = r_q.fb;
endmodule

// File: rtl/asyn_macrocell.sv
module asyn_macrocell #(
    parameter int N_IN  = 10,
    parameter int N_DAT = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0]               dev_in,
    input  logic                          oe_pin_n,
    input  logic                          preload_n,
    input  logic                          pad_in,
    input  logic [N_DAT*2*(N_IN+1)-1:0]   fuse_data,
    input  logic [2*(N_IN+1)-1:0]         fuse_clk,
    input  logic [2*(N_IN+1)-1:0]         fuse_set,
    input  logic [2*(N_IN+1)-1:0]         fuse_rst,
    input  logic [2*(N_IN+1)-1:0]         fuse_oe,
    input  logic                          cfg_active_high,
    output logic                          pad_out,
    output logic                          pad_oe
);
    localparam int N = N_IN + 1;

    logic [N-1:0] lits;
    logic sum, clk_t, set_t, rst_t, oe_t;
    logic state_q, fb_q;
    logic comb_mode, sel_val, pad_level;

    assign lits = {fb_q, dev_in};

    pt_array #(.N(N), .N_DAT(N_DAT)) u_array (
        .lits      (lits),
        .fuse_data (fuse_data),
        .fuse_clk  (fuse_clk),
        .fuse_set  (fuse_set),
        .fuse_rst  (fuse_rst),
        .fuse_oe   (fuse_oe),
        .sum       (sum),
        .clk_t     (clk_t),
        .set_t     (set_t),
        .rst_t     (rst_t),
        .oe_t      (oe_t)
    );

    assign comb_mode = set_t & rst_t;
    assign sel_val   = comb_mode ? sum : state_q;
    assign pad_out   = cfg_active_high ? sel_val : ~sel_val;
    assign pad_oe    = oe_t & ~oe_pin_n;
    assign pad_level = pad_oe ? pad_out : pad_in;

    mc_state u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload_n   (preload_n),
        .pad_in      (pad_in),
        .active_high (cfg_active_high),
        .sum         (sum),
        .clk_t       (clk_t),
        .set_t       (set_t),
        .rst_t       (rst_t),
        .pad_level   (pad_level),
        .state_q     (state_q),
        .fb_q        (fb_q)
    );
endmodule

// File: rtl/asyn_macrocell_chk.sv
module asyn_macrocell_chk (
    input logic clk,
    input logic rst_n,
    input logic oe_pin_n,
    input logic preload_n,
    input logic pad_in,
    input logic cfg_active_high,
    input logic set_t,
    input logic rst_t,
    input logic state_q,
    input logic pad_oe
);
    p_pin_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_pin_n |-> !pad_oe);

    p_comb_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_n && set_t && rst_t) |=> $stable(state_q));

    p_set_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_n && set_t && !rst_t) |=> state_q);

    p_reset_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_n && rst_t && !set_t) |=> !state_q);

    p_preload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_n |=> (state_q == ($past(cfg_active_high) ? $past(pad_in) : !$past(pad_in))));
endmodule

bind asyn_macrocell asyn_macrocell_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .oe_pin_n        (oe_pin_n),
    .preload_n       (preload_n),
    .pad_in          (pad_in),
    .cfg_active_high (cfg_active_high),
    .set_t           (set_t),
    .rst_t           (rst_t),
    .state_q         (state_q),
    .pad_oe          (pad_oe)
);

// File: tb/asyn_macrocell_bench.sv
module asyn_macrocell_bench;
    localparam int N_IN = 10;
    localparam int N    = N_IN + 1;
    localparam int MW   = 2 * N;

    logic clk = 1'b0;
    logic rst_n;
    logic [N_IN-1:0] dev_in;
    logic oe_pin_n, preload_n, pad_in, cfg_active_high;
    logic [4*MW-1:0] fuse_data;
    logic [MW-1:0] fuse_clk, fuse_set, fuse_rst, fuse_oe;
    logic pad_out, pad_oe;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    asyn_macrocell #(.N_IN(N_IN)) u_asyn_macrocell (
        .clk(clk), .rst_n(rst_n), .dev_in(dev_in), .oe_pin_n(oe_pin_n),
        .preload_n(preload_n), .pad_in(pad_in), .fuse_data(fuse_data),
        .fuse_clk(fuse_clk), .fuse_set(fuse_set), .fuse_rst(fuse_rst),
        .fuse_oe(fuse_oe), .cfg_active_high(cfg_active_high),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // one literal: bit 2*idx (true) or 2*idx+1 (complement)
    function automatic logic [MW-1:0] lit(int idx, bit neg);
        logic [MW-1:0] m;
        m = '0;
        m[2*idx + (neg ? 1 : 0)] = 1'b1;
        return m;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // {in2, in1, in0, expected} for data = in0 | (in1 & in2)
    localparam logic [3:0] CVEC [0:7] = '{
        4'b000_0, 4'b001_1, 4'b010_0, 4'b011_1,
        4'b100_0, 4'b101_1, 4'b110_1, 4'b111_1
    };

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; dev_in = '0; oe_pin_n = 1'b0; preload_n = 1'b1;
        pad_in = 1'b0; cfg_active_high = 1'b0;
        fuse_data = {4{{MW{1'b1}}}};
        fuse_clk = lit(7, 0); fuse_set = lit(8, 0); fuse_rst = lit(9, 0);
        fuse_oe = lit(6, 1);
        fuse_data[0 +: MW] = lit(0, 0);
        repeat (3) tick();
        // R8: cleared state, active-low pad reads high
        check("R8 active-low after reset", pad_out, 1'b1);
        rst_n = 1'b1;
        tick();
        cfg_active_high = 1'b1;
        #1 check("R8 active-high after reset", pad_out, 1'b0);

        // R2: registered capture only on rising clock term
        dev_in[0] = 1'b1;
        tick();
        check("R2 no capture without edge", pad_out, 1'b0);
        dev_in[7] = 1'b1;
        tick();
        check("R2 capture on rising edge", pad_out, 1'b1);
        dev_in[0] = 1'b0;
        tick();
        check("R2 high level no capture", pad_out, 1'b1);
        dev_in[7] = 1'b0;
        tick(); tick();
        check("R2 falling edge no capture", pad_out, 1'b1);

        // R5: set/reset beat a simultaneous clock edge
        dev_in[9] = 1'b1;
        tick();
        check("R5 reset only", pad_out, 1'b0);
        dev_in[9] = 1'b0; dev_in[8] = 1'b1; dev_in[7] = 1'b1; dev_in[0] = 1'b0;
        tick();
        check("R5 set beats clock", pad_out, 1'b1);
        dev_in[8] = 1'b0; dev_in[7] = 1'b0;
        tick();
        dev_in[9] = 1'b1; dev_in[7] = 1'b1; dev_in[0] = 1'b1;
        tick();
        check("R5 reset beats clock", pad_out, 1'b0);
        dev_in[9] = 1'b0; dev_in[7] = 1'b0; dev_in[0] = 1'b0;
        tick();

        // R4: both high -> combinatorial, state held
        dev_in[8] = 1'b1; dev_in[9] = 1'b1; dev_in[0] = 1'b1;
        #1 check("R4 comb follows data", pad_out, 1'b1);
        tick();
        dev_in[0] = 1'b0;
        #1 check("R4 comb follows data low", pad_out, 1'b0);
        dev_in[0] = 1'b1;
        tick();
        dev_in[8] = 1'b0; dev_in[9] = 1'b0;
        #1 check("R4 held state reappears", pad_out, 1'b0);
        dev_in[0] = 1'b0;
        tick();

        // R3: enable gating
        check("R3 driven", pad_oe, 1'b1);
        oe_pin_n = 1'b1;
        #1 check("R3 pin high disables", pad_oe, 1'b0);
        oe_pin_n = 1'b0; dev_in[6] = 1'b1;
        #1 check("R3 term low disables", pad_oe, 1'b0);
        dev_in[6] = 1'b0;

        // R7: preload from pad, both polarities
        pad_in = 1'b1; preload_n = 1'b0;
        tick();
        preload_n = 1'b1; pad_in = 1'b0;
        #1 check("R7 preload active high", pad_out, 1'b1);
        cfg_active_high = 1'b0; pad_in = 1'b0; preload_n = 1'b0;
        tick();
        preload_n = 1'b1; pad_in = 1'b1;
        #1 check("R7 preload active low", pad_out, 1'b0);
        cfg_active_high = 1'b1; pad_in = 1'b0;

        // R9: feedback state machine toggles
        dev_in[9] = 1'b1;
        tick();
        dev_in[9] = 1'b0;
        fuse_data[0 +: MW] = lit(10, 1);
        tick(); tick();
        dev_in[7] = 1'b1;
        tick();
        dev_in[7] = 1'b0;
        check("R9 toggle to one", pad_out, 1'b1);
        tick(); tick();
        dev_in[7] = 1'b1;
        tick();
        dev_in[7] = 1'b0;
        check("R9 toggle to zero", pad_out, 1'b0);

        // Combinatorial table walk (R2 OR of terms, R1 masks)
        fuse_set = '0; fuse_rst = '0; fuse_oe = '0;
        fuse_data = {4{{MW{1'b1}}}};
        fuse_data[0 +: MW]  = lit(0, 0);
        fuse_data[MW +: MW] = lit(1, 0) | lit(2, 0);
        dev_in = '0;
        for (int v = 0; v < 8; v++) begin
            dev_in[2:0] = CVEC[v][3:1];
            #1 check("R2 OR of data terms", pad_out, CVEC[v][0]);
        end

        // R6: polarity inverts
        dev_in[2:0] = 3'b001;
        cfg_active_high = 1'b0;
        #1 check("R6 active low inverts", pad_out, 1'b0);
        cfg_active_high = 1'b1;

        // R1: all-intact term low, empty term high
        fuse_data[0 +: MW] = {MW{1'b1}};
        #1 check("R1 all fuses intact low", pad_out, 1'b0);
        fuse_data[0 +: MW] = '0;
        dev_in = '0;
        #1 check("R1 empty term high", pad_out, 1'b1);

        // R9: disabled cell reads pad_in through feedback
        fuse_data = {4{{MW{1'b1}}}};
        fuse_data[0 +: MW] = lit(10, 0);
        oe_pin_n = 1'b1; pad_in = 1'b1;
        tick();
        check("R9 pad input high", pad_out, 1'b1);
        pad_in = 1'b0;
        tick();
        check("R9 pad input low", pad_out, 1'b0);

        finish_up();
    end
endmodule